// File: doc/BRIEF.md
# Mode-Steered Multiply-Accumulate Datapath

This block is a registered arithmetic slice. A 7-bit mode word controls three operand selectors, called X, Y and Z. A three-input adder/subtracter combines the three selected operands, and the result is written into a 48-bit accumulator register P. Selectable sources include:

- the signed product of a 25-bit A and an 18-bit B;
- the zero-extended concatenation of A and B;
- a 48-bit C operand;
- an all-ones constant;
- a 48-bit cascade input;
- the accumulator itself;
- the cascade input or the accumulator, arithmetically shifted right by 17 bits.

The accumulator is also driven out on a cascade output, so slices can be chained.

Some mode words are not allowed. A flag reports them in the same cycle the mode is presented, and the accumulator keeps its value while such a mode is applied. A typical use is a wide multiply: one slice forms a partial product, and the next slice adds its own product to the upper bits of the first slice's result, taken through the shifted cascade path.

Top module: `opmac_top`

## Requirements
- R1: Mode bits [1:0] select X: 00 gives zero, 01 gives the product (paired with Y), 10 gives P, 11 gives {A,B} zero-extended to 48 bits.
- R2: Mode bits [3:2] select Y: 00 gives zero, 01 gives the product (paired with X), 10 gives all ones, 11 gives C.
- R3: Mode bits [6:4] select Z: 000 zero, 001 cascade input, 010 P, 011 C, 100 P, 101 cascade input shifted, 110 P shifted; 111 is not allowed.
- R4: With X=01 and Y=01, X+Y equals the signed product of A and B, sign-extended to 48 bits. Repeating this with Z=010 accumulates the product.
- R5: The two shifted Z sources are arithmetic right shifts by 17 that copy bit 47 into the vacated upper bits.
- R6: With sub=1 the next P is Z-(X+Y). With sub=0 it is Z+X+Y.
- R7: Arithmetic wraps modulo 2^48.
- R8: `illegal` is 1, combinationally, in three cases: exactly one of X and Y is 01; Z is 111; Z is 100 without Y=10 and X=00. In all other modes it is 0.
- R9: While `illegal` is 1 and ce is 1, P keeps its value.
- R10: P updates on the rising edge only when ce=1. A synchronous rst clears P to zero and overrides ce.
- R11: `pcout` equals P at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of P |
| ce | input | 1 | Clock enable for P |
| a | input | 25 | Signed multiplier operand |
| b | input | 18 | Signed multiplier operand |
| c | input | 48 | General operand |
| pcin | input | 48 | Cascade input |
| mode | input | 7 | Operand selection word {Z[2:0], Y[1:0], X[1:0]} |
| sub | input | 1 | 1: subtract X+Y from Z |
| p | output | 48 | Accumulator register |
| pcout | output | 48 | Cascade output, copy of P |
| illegal | output | 1 | Disallowed mode combination |

## Verification
On every cycle, the assertions check four things: the flag against the three forbidden pairings, P holding while ce is low or the mode is flagged, reset clearing P, and an add of zero to P leaving P unchanged. The operand routing itself can only be shown by the bench scenarios. These cover all 128 mode words under both add and subtract, with signed extreme operands. They also cover the product split, the sign fill of the shifts, and wrap-around. Each result is compared against an arithmetic model in the bench.

// File: rtl/opmac_pkg.sv
package opmac_pkg;

    localparam int OPM_A_W   = 25;
    localparam int OPM_B_W   = 18;
    localparam int OPM_P_W   = 48;
    localparam int OPM_SHIFT = 17;

    typedef enum logic [1:0] {
        XS_ZERO = 2'b00,
        XS_MUL  = 2'b01,
        XS_ACC  = 2'b10,
        XS_AB   = 2'b11
    } xsel_e;

    typedef enum logic [1:0] {
        YS_ZERO = 2'b00,
        YS_MUL  = 2'b01,
        YS_ONES = 2'b10,
        YS_C    = 2'b11
    } ysel_e;

    typedef enum logic [2:0] {
        ZS_ZERO    = 3'b000,
        ZS_CASC    = 3'b001,
        ZS_ACC     = 3'b010,
        ZS_C       = 3'b011,
        ZS_ACC_EXT = 3'b100,
        ZS_CASC_SH = 3'b101,
        ZS_ACC_SH  = 3'b110,
        ZS_BAD     = 3'b111
    } zsel_e;

    typedef struct packed {
        zsel_e z;
        ysel_e y;
        xsel_e x;
    } mode_t;

    // A mode is rejected when the product halves are split across X and Y,
    // when Z uses its reserved code, or when the extension code is paired
    // with anything but Y=ones, X=zero.
    function automatic logic mode_bad(mode_t m);
        logic split_mul;
        logic ext_bad;
        split_mul = (m.x == XS_MUL) ^ (m.y == YS_MUL);
        ext_bad   = (m.z == ZS_ACC_EXT) && !((m.y == YS_ONES) && (m.x == XS_ZERO));
        return split_mul || ext_bad || (m.z == ZS_BAD);
    endfunction

endpackage

// File: rtl/opmac_mul.sv
module opmac_mul
    import opmac_pkg::*;
#(
    parameter int A_W = OPM_A_W,
    parameter int B_W = OPM_B_W,
    parameter int P_W = OPM_P_W
) (
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic [P_W-1:0] pp_hi,
    output logic [P_W-1:0] pp_lo
);
    localparam int PR_W = A_W + B_W;
    localparam int HALF = P_W / 2;

    logic signed [PR_W-1:0] prod;
    logic        [P_W-1:0]  prod_ext;

    always_comb begin
        prod     = $signed(a) * $signed(b);
        prod_ext = {{(P_W-PR_W){prod[PR_W-1]}}, prod};
    end

    // Two partial terms whose sum is the full product: upper half and lower half.
    assign pp_hi = {prod_ext[P_W-1:HALF], {HALF{1'b0}}};
    assign pp_lo = {{(P_W-HALF){1'b0}}, prod_ext[HALF-1:0]};

endmodule

// File: rtl/opmac_opsel.sv
module opmac_opsel
    import opmac_pkg::*;
#(
    parameter int P_W   = OPM_P_W,
    parameter int SHIFT = OPM_SHIFT
) (
    input  mode_t          mode,
    input  logic [P_W-1:0] pp_hi,
    input  logic [P_W-1:0] pp_lo,
    input  logic [P_W-1:0] acc,
    input  logic [P_W-1:0] ab,
    input  logic [P_W-1:0] c,
    input  logic [P_W-1:0] pcin,
    output logic [P_W-1:0] xo,
    output logic [P_W-1:0] yo,
    output logic [P_W-1:0] zo,
    output logic           illegal
);
    logic [P_W-1:0] casc_sh;
    logic [P_W-1:0] acc_sh;

    assign casc_sh = P_W'($signed(pcin) >>> SHIFT);
    assign acc_sh  = P_W'($signed(acc) >>> SHIFT);

    always_comb begin
        case (mode.x)
            XS_ZERO: xo = '0;
            XS_MUL:  xo = pp_hi;
            XS_ACC:  xo = acc;
            XS_AB:   xo = ab;
            default: xo = '0;
        endcase
    end

    always_comb begin
        case (mode.y)
            YS_ZERO: yo = '0;
            YS_MUL:  yo = pp_lo;
            YS_ONES: yo = '1;
            YS_C:    yo = c;
            default: yo = '0;
        endcase
    end

    always_comb begin
        case (mode.z)
            ZS_ZERO:    zo = '0;
            ZS_CASC:    zo = pcin;
            ZS_ACC:     zo = acc;
            ZS_C:       zo = c;
            ZS_ACC_EXT: zo = acc;
            ZS_CASC_SH: zo = casc_sh;
            ZS_ACC_SH:  zo = acc_sh;
            default:    zo = '0;
        endcase
    end

    assign illegal = mode_bad(mode);

endmodule

// File: rtl/opmac_addsub.sv
module opmac_addsub
    import opmac_pkg::*;
#(
    parameter int P_W = OPM_P_W
) (
    input  logic [P_W-1:0] xo,
    input  logic [P_W-1:0] yo,
    input  logic [P_W-1:0] zo,
    input  logic           sub,
    output logic [P_W-1:0] res
);
    logic [P_W-1:0] xy;

    always_comb begin
        xy  = xo + yo;
        res = sub ? (zo - xy) : (zo + xy);
    end

endmodule

// File: rtl/opmac_top.sv
module opmac_top
    import opmac_pkg::*;
#(
    parameter int A_W   = OPM_A_W,
    parameter int B_W   = OPM_B_W,
    parameter int P_W   = OPM_P_W,
    parameter int SHIFT = OPM_SHIFT
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ce,
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    input  logic [P_W-1:0] c,
    input  logic [P_W-1:0] pcin,
    input  logic [6:0]     mode,
    input  logic           sub,
    output logic [P_W-1:0] p,
    output logic [P_W-1:0] pcout,
    output logic           illegal
);
    localparam int AB_W = A_W + B_W;

    mode_t          m;
    logic [P_W-1:0] pp_hi, pp_lo, ab, xo, yo, zo, res;
    logic [P_W-1:0] p_q;

    assign m = mode_t'(mode);

    always_comb begin
        ab           = '0;
        ab[AB_W-1:0] = {a, b};
    end

    opmac_mul #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) u_mul (
        .a(a), .b(b), .pp_hi(pp_hi), .pp_lo(pp_lo)
    );

    opmac_opsel #(.P_W(P_W), .SHIFT(SHIFT)) u_sel (
        .mode(m), .pp_hi(pp_hi), .pp_lo(pp_lo), .acc(p_q), .ab(ab),
        .c(c), .pcin(pcin), .xo(xo), .yo(yo), .zo(zo), .illegal(illegal)
    );

    opmac_addsub #(.P_W(P_W)) u_add (
        .xo(xo), .yo(yo), .zo(zo), .sub(sub), .res(res)
    );

    always_ff @(posedge clk) begin
        if (rst)
            p_q <= '0;
        else if (ce && !illegal)
            p_q <= res;
    end

    assign p     = p_q;
    assign pcout = p_q;

    // R10: reset clears the accumulator regardless of ce
    assert_rst_clear_R10: assert property (@(posedge clk) rst |=> (p == '0));

    // R10: no update without clock enable
    assert_ce_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(p));

    // R9: flagged modes leave the accumulator untouched
    assert_illegal_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (ce && illegal) |=> $stable(p));

    // R8: product halves split across X and Y must be flagged
    assert_split_mul_R8: assert property (@(posedge clk) disable iff (rst)
        ((mode[1:0] == 2'b01) != (mode[3:2] == 2'b01)) |-> illegal);

    // R8: reserved Z code and misused extension code must be flagged
    assert_zcode_R8: assert property (@(posedge clk) disable iff (rst)
        ((mode[6:4] == 3'b111) || ((mode[6:4] == 3'b100) && (mode[3:0] != 4'b1000))) |-> illegal);

    // R3: Z=P plus zero operands, adding, leaves P unchanged
    assert_acc_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (ce && !sub && mode == 7'b0100000) |=> $stable(p));

endmodule

// File: tb/opmac_top_test.sv
`timescale 1ns/1ps
module opmac_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce  = 1'b1;
    logic [24:0] a   = '0;
    logic [17:0] b   = '0;
    logic [47:0] c   = '0;
    logic [47:0] pcin = '0;
    logic [6:0]  mode = '0;
    logic        sub  = 1'b0;
    logic [47:0] p, pcout;
    logic        illegal;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    opmac_top uut (
        .clk(clk), .rst(rst), .ce(ce), .a(a), .b(b), .c(c), .pcin(pcin),
        .mode(mode), .sub(sub), .p(p), .pcout(pcout), .illegal(illegal)
    );

    task automatic chk(input logic ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s mode=%b actual=%h expected=%h", tag, mode, act, exp);
        end
    endtask

    function automatic logic [47:0] asr17(input logic [47:0] v);
        return {{17{v[47]}}, v[47:17]};
    endfunction

    function automatic logic bad_mode(input logic [6:0] md);
        logic [1:0] x; logic [1:0] y; logic [2:0] z;
        x = md[1:0]; y = md[3:2]; z = md[6:4];
        return ((x == 2'd1) != (y == 2'd1)) || (z == 3'd7) ||
               (z == 3'd4 && !(y == 2'd2 && x == 2'd0));
    endfunction

    function automatic logic [47:0] model(input logic [6:0] md, input logic [24:0] va,
            input logic [17:0] vb, input logic [47:0] vc, input logic [47:0] vpc,
            input logic vs, input logic [47:0] pold);
        logic signed [47:0] sa, sb;
        logic [47:0] xv, yv, zv, xy;
        sa = {{23{va[24]}}, va};
        sb = {{30{vb[17]}}, vb};
        case (md[1:0])
            2'd0: xv = '0;
            2'd1: xv = '0;
            2'd2: xv = pold;
            default: xv = {5'd0, va, vb};
        endcase
        case (md[3:2])
            2'd0: yv = '0;
            2'd1: yv = sa * sb;
            2'd2: yv = '1;
            default: yv = vc;
        endcase
        case (md[6:4])
            3'd0: zv = '0;
            3'd1: zv = vpc;
            3'd2, 3'd4: zv = pold;
            3'd3: zv = vc;
            3'd5: zv = asr17(vpc);
            default: zv = asr17(pold);
        endcase
        xy = xv + yv;
        return vs ? zv - xy : zv + xy;
    endfunction

    // drive on the falling edge, let one rising edge pass, sample 1 ns later
    task automatic step(input logic [6:0] md, input logic [24:0] va, input logic [17:0] vb,
            input logic [47:0] vc, input logic [47:0] vpc, input logic vs);
        @(negedge clk);
        mode = md; a = va; b = vb; c = vc; pcin = vpc; sub = vs;
        @(posedge clk);
        #1;
    endtask

    task automatic preload(input logic [47:0] v);
        step(7'b0110000, '0, '0, v, '0, 1'b0);
    endtask

    function automatic string tag_of(input logic [6:0] md, input logic vs);
        if (md[6:4] == 3'd5 || md[6:4] == 3'd6) return "R5";
        if (md[1:0] == 2'd1) return "R4";
        if (vs) return "R6";
        if (md[6:4] != 3'd0) return "R3";
        if (md[3:2] != 2'd0) return "R2";
        return "R1";
    endfunction

    initial begin
        #1_500_000;
        errors++; checks++;
        $display("FAIL watchdog expired, all requirements");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [24:0] va; logic [17:0] vb; logic [47:0] vc, vpc, pre, exp_p;
        repeat (2) @(posedge clk);
        #1;
        chk(p == '0, "R10 reset", p, '0);
        @(negedge clk); rst = 1'b0;

        // R10: ce low holds, reset overrides ce
        preload(48'h0000_1234_5678);
        @(negedge clk); ce = 1'b0;
        step(7'b0110000, '0, '0, 48'hAAAA_0000_5555, '0, 1'b0);
        chk(p == 48'h0000_1234_5678, "R10 ce hold", p, 48'h0000_1234_5678);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk(p == '0, "R10 reset over ce", p, '0);
        @(negedge clk); rst = 1'b0; ce = 1'b1;

        // R7: all ones plus one wraps to zero
        step(7'b0001000, '0, '0, '0, '0, 1'b0);
        chk(p == 48'hFFFF_FFFF_FFFF, "R2 ones", p, 48'hFFFF_FFFF_FFFF);
        step(7'b0100011, 25'd0, 18'd1, '0, '0, 1'b0);
        chk(p == '0, "R7 wrap", p, '0);

        // R5: sign fill of the shifted accumulator
        preload(48'h8000_0000_0000);
        step(7'b1100000, '0, '0, '0, '0, 1'b0);
        chk(p == 48'hFFFF_C000_0000, "R5 sign fill", p, 48'hFFFF_C000_0000);

        // R4: accumulate signed product three times: (-3)*(7)
        preload('0);
        for (int k = 1; k <= 3; k++) begin
            step(7'b0100101, 25'h1FFFFFD, 18'd7, '0, '0, 1'b0);
            chk(p == 48'(-21 * k), "R4 accumulate", p, 48'(-21 * k));
        end

        // full sweep over every mode word, both operations, four operand sets
        for (int vi = 0; vi < 4; vi++) begin
            case (vi)
                0: begin va = 25'd5; vb = 18'd3; vc = 48'h1234_5678_9ABC; vpc = 48'h8000_0000_0001; end
                1: begin va = 25'h1FFFFFF; vb = 18'h1FFFF; vc = 48'hFFFF_FFFF_FFF0; vpc = 48'h7FFF_FFFF_FFFF; end
                2: begin va = 25'h1000000; vb = 18'h20000; vc = 48'h8000_0000_0000; vpc = 48'h0000_0001_2345; end
                default: begin va = 25'h0ABCDE; vb = 18'h3FFFE; vc = 48'h0F0F_F0F0_0F0F; vpc = 48'hFFFF_FFFF_FFFF; end
            endcase
            pre = vc ^ 48'hC3A5_5A3C_9669;
            for (int s = 0; s < 2; s++) begin
                for (int md = 0; md < 128; md++) begin
                    preload(pre);
                    @(negedge clk);
                    mode = 7'(md); a = va; b = vb; c = vc; pcin = vpc; sub = s[0];
                    #1;
                    chk(illegal == bad_mode(7'(md)), "R8 flag", {47'd0, illegal}, {47'd0, bad_mode(7'(md))});
                    @(posedge clk); #1;
                    if (bad_mode(7'(md))) begin
                        chk(p == pre, "R9 hold", p, pre);
                    end else begin
                        exp_p = model(7'(md), va, vb, vc, vpc, s[0], pre);
                        chk(p == exp_p, tag_of(7'(md), s[0]), p, exp_p);
                    end
                    chk(pcout == p, "R11 cascade copy", pcout, p);
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule